// File: doc/BRIEF.md
# Re-synchronised Raster Timing Generator

This block produces the pixel and line coordinates, the horizontal and vertical sync pulses, an active-video flag and a line-start strobe for a scan-doubled output raster. By default the raster shows 640 by 400 visible pixels. The line is 800 clocks long and the frame is 449 lines tall. This gives a line rate near 31 kHz, which is twice the line rate of the slower source video.

The two counters run freely, but the source frame still steers the vertical one. The vertical sync from the source passes through a synchroniser. On each active edge, the line counter is loaded with a fixed value, 435 by default. That value falls in the vertical back porch, so the output frame follows the source frame and the blanking band does not creep across the screen. When no source sync arrives, the counters still wrap by themselves and the raster keeps running. The line-start strobe tells a line-buffer reader when to begin fetching the next line.

Top module: `sync_relock_gen`

## Requirements
- R1: While rst_ni is low the outputs are x_o=0, y_o=0, hsync_o=0, vsync_o=0, active_o=1 and line_start_o=1.
- R2: x_o advances by one on every clock and wraps from H_TOTAL-1 to 0, where H_TOTAL = H_ACTIVE+H_FRONT+H_SYNC+H_BACK (800 by default).
- R3: y_o advances by one on the clock edge where x_o wraps, and holds its value on every other edge.
- R4: Without an external sync, y_o wraps from V_TOTAL-1 to 0, where V_TOTAL = V_ACTIVE+V_FRONT+V_SYNC+V_BACK (449 by default).
- R5: A rising edge on ext_vsync_i (active-high default) loads y_o with Y_PRELOAD (435 by default). The load happens on the third rising clock edge that samples the new level, and it takes priority over the line increment on that edge.
- R6: hsync_o is 1 exactly when H_ACTIVE+H_FRONT <= x_o < H_ACTIVE+H_FRONT+H_SYNC.
- R7: vsync_o is 1 exactly when V_ACTIVE+V_FRONT <= y_o < V_ACTIVE+V_FRONT+V_SYNC.
- R8: active_o is 1 exactly when x_o < H_ACTIVE and y_o < V_ACTIVE.
- R9: line_start_o is 1 exactly when x_o is 0.
- R10: A level on ext_vsync_i held high, and a falling edge, load nothing: only a new rising edge loads y_o again.
- R11: A load of y_o leaves x_o untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_vsync_i | input | 1 | Vertical sync from the source system, asynchronous |
| x_o | output | XW (10) | Horizontal pixel coordinate |
| y_o | output | YW (9) | Vertical line coordinate |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| active_o | output | 1 | Visible area flag |
| line_start_o | output | 1 | High while x_o is 0 |

## Verification
A faulty horizontal counter shows up on x_o in the first cycle after the fault. It then puts line_start_o and hsync_o out of step within one line. A faulty vertical counter, or a faulty preload, leaves y_o wrong right away. Worse, it moves vsync_o and the blanking band by whole lines, and that error lasts until the next good source edge. A wrong synchroniser depth or edge polarity moves the load by a single clock, or repeats it while the source level is held. The bench therefore sweeps pulses across every position in the line, including the line-wrap edge, and compares every output on every cycle.

// File: rtl/sync_relock_pkg.sv
package sync_relock_pkg;

  // true when v lies in [lo, lo+len)
  function automatic logic in_span(input int unsigned v, input int unsigned lo,
                                   input int unsigned len);
    return (v >= lo) && (v < lo + len);
  endfunction

endpackage

// File: rtl/srg_vs_edge.sv
module srg_vs_edge #(
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vs_async_i,
  output logic vs_edge_o
);
  localparam bit IDLE = !ACTIVE_HIGH;

  // [0],[1] synchroniser, [2] edge history
  logic [2:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {3{IDLE}};
    else         pipe_q <= {pipe_q[1:0], vs_async_i};
  end

  generate
    if (ACTIVE_HIGH) begin : g_rise
      assign vs_edge_o = pipe_q[1] & ~pipe_q[2];
    end else begin : g_fall
      assign vs_edge_o = ~pipe_q[1] & pipe_q[2];
    end
  endgenerate

  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_edge_o |=> !vs_edge_o);

endmodule

// File: rtl/srg_hcount.sv
module srg_hcount #(
  parameter int unsigned H_TOTAL = 800,
  parameter int unsigned XW      = $clog2(H_TOTAL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [XW-1:0] x_o,
  output logic          line_end_o
);
  localparam logic [XW-1:0] X_LAST = XW'(H_TOTAL - 1);

  logic [XW-1:0] x_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            x_q <= '0;
    else if (x_q == X_LAST) x_q <= '0;
    else                    x_q <= x_q + 1'b1;
  end

  assign x_o        = x_q;
  assign line_end_o = (x_q == X_LAST);

  a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_q == X_LAST) |=> (x_q == '0));
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_q != X_LAST) |=> (x_q == $past(x_q) + 1'b1));

endmodule

// File: rtl/srg_vcount.sv
module srg_vcount #(
  parameter int unsigned V_TOTAL   = 449,
  parameter int unsigned Y_PRELOAD = 435,
  parameter int unsigned YW        = $clog2(V_TOTAL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_end_i,
  input  logic          preload_i,
  output logic [YW-1:0] y_o
);
  localparam logic [YW-1:0] Y_LAST = YW'(V_TOTAL - 1);
  localparam logic [YW-1:0] Y_LOAD = YW'(Y_PRELOAD);

  logic [YW-1:0] y_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         y_q <= '0;
    else if (preload_i)  y_q <= Y_LOAD;   // source sync wins over line step
    else if (line_end_i) y_q <= (y_q == Y_LAST) ? '0 : y_q + 1'b1;
  end

  assign y_o = y_q;

  a_r5_preload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preload_i |=> (y_q == Y_LOAD));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!preload_i && !line_end_i) |=> $stable(y_q));
  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!preload_i && line_end_i && y_q == Y_LAST) |=> (y_q == '0));

endmodule

// File: rtl/sync_relock_gen.sv
module sync_relock_gen #(
  parameter int unsigned H_ACTIVE  = 640,
  parameter int unsigned H_FRONT   = 16,
  parameter int unsigned H_SYNC    = 96,
  parameter int unsigned H_BACK    = 48,
  parameter int unsigned V_ACTIVE  = 400,
  parameter int unsigned V_FRONT   = 12,
  parameter int unsigned V_SYNC    = 2,
  parameter int unsigned V_BACK    = 35,
  parameter int unsigned Y_PRELOAD = 435,
  parameter bit          EXT_VS_HIGH = 1'b1,
  parameter int unsigned XW = $clog2(H_ACTIVE + H_FRONT + H_SYNC + H_BACK),
  parameter int unsigned YW = $clog2(V_ACTIVE + V_FRONT + V_SYNC + V_BACK)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ext_vsync_i,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          active_o,
  output logic          line_start_o
);
  import sync_relock_pkg::*;

  localparam int unsigned H_TOTAL  = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int unsigned V_TOTAL  = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int unsigned HS_START = H_ACTIVE + H_FRONT;
  localparam int unsigned VS_START = V_ACTIVE + V_FRONT;

  logic          vs_edge;
  logic          line_end;
  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;

  srg_vs_edge #(.ACTIVE_HIGH(EXT_VS_HIGH)) u_vs_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vs_async_i (ext_vsync_i),
    .vs_edge_o  (vs_edge)
  );

  srg_hcount #(.H_TOTAL(H_TOTAL), .XW(XW)) u_hcount (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .x_o        (x_q),
    .line_end_o (line_end)
  );

  srg_vcount #(.V_TOTAL(V_TOTAL), .Y_PRELOAD(Y_PRELOAD), .YW(YW)) u_vcount (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_end_i (line_end),
    .preload_i  (vs_edge),
    .y_o        (y_q)
  );

  assign x_o          = x_q;
  assign y_o          = y_q;
  assign hsync_o      = in_span(32'(x_q), HS_START, H_SYNC);
  assign vsync_o      = in_span(32'(y_q), VS_START, V_SYNC);
  assign active_o     = (32'(x_q) < H_ACTIVE) && (32'(y_q) < V_ACTIVE);
  assign line_start_o = (x_q == '0);

  a_r6_hsync_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_o |-> !active_o);
  a_r7_vsync_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o |-> !active_o);
  a_r9_start_after_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_end |=> line_start_o);
  a_r11_x_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_edge && !line_end) |=> (x_o == $past(x_o) + 1'b1));

endmodule

// File: tb/sync_relock_gen_tb.sv
module sync_relock_gen_tb;
  localparam int HA = 8, HF = 2, HS = 3, HB = 3;
  localparam int VA = 6, VF = 2, VS = 2, VB = 3;
  localparam int PRE = 10;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int XW = $clog2(HT);
  localparam int YW = $clog2(VT);

  typedef struct {
    int    x;
    int    y;
    bit    hs, vs, act, ls;
    string xtag;
    string ytag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ext_vsync_i = 1'b0;
  logic [XW-1:0] x_o;
  logic [YW-1:0] y_o;
  logic          hsync_o, vsync_o, active_o, line_start_o;

  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];

  int       mx = 0;
  int       my = 0;
  bit [3:0] hist = '0;

  always #2 clk = ~clk;

  sync_relock_gen #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
    .Y_PRELOAD(PRE), .EXT_VS_HIGH(1'b1)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_vsync_i(ext_vsync_i),
    .x_o(x_o), .y_o(y_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .active_o(active_o), .line_start_o(line_start_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // model of the next clock edge, from the requirements
  task automatic push_model(input bit lvl);
    exp_t e;
    bit   pre, wrap_line, wrap_frame;
    hist       = {hist[2:0], lvl};
    pre        = hist[2] && !hist[3];            // R5: third sampling edge
    wrap_line  = (mx == HT - 1);
    wrap_frame = 1'b0;
    mx = wrap_line ? 0 : mx + 1;
    if (pre) my = PRE;
    else if (wrap_line) begin
      wrap_frame = (my == VT - 1);
      my = wrap_frame ? 0 : my + 1;
    end
    e.x    = mx;
    e.y    = my;
    e.hs   = (mx >= HA + HF) && (mx < HA + HF + HS);
    e.vs   = (my >= VA + VF) && (my < VA + VF + VS);
    e.act  = (mx < HA) && (my < VA);
    e.ls   = (mx == 0);
    e.xtag = pre ? "R11" : "R2";
    e.ytag = pre ? "R5" : (hist[3] ? "R10" : (wrap_frame ? "R4" : "R3"));
    sb_q.push_back(e);
  endtask

  task automatic step(input bit lvl);
    @(negedge clk);
    ext_vsync_i = lvl;
    push_model(lvl);
  endtask

  task automatic run(input int n, input bit lvl);
    for (int i = 0; i < n; i++) step(lvl);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.xtag, int'(x_o), e.x);
        check(e.ytag, int'(y_o), e.y);
        check("R6", int'(hsync_o), int'(e.hs));
        check("R7", int'(vsync_o), int'(e.vs));
        check("R8", int'(active_o), int'(e.act));
        check("R9", int'(line_start_o), int'(e.ls));
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", int'(x_o), 0);
    check("R1", int'(y_o), 0);
    check("R1", int'(hsync_o), 0);
    check("R1", int'(vsync_o), 0);
    check("R1", int'(active_o), 1);
    check("R1", int'(line_start_o), 1);

    @(negedge clk);
    rst_ni      = 1'b1;
    ext_vsync_i = 1'b0;
    push_model(1'b0);

    // R2 R3 R4: free-running over more than two frames
    run(HT * VT * 2 + 37, 1'b0);

    // R5 R11: pulses swept across every line position, incl. line wrap
    for (int off = 0; off < HT + 2; off++) begin
      run(off + 20, 1'b0);
      run(4, 1'b1);
    end
    run(40, 1'b0);

    // R10: long hold, then falling edge, then a fresh rising edge
    run(3, 1'b1);
    run(HT * 6, 1'b1);
    run(HT * 3, 1'b0);
    run(1, 1'b1);
    run(HT * VT, 1'b0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule